// File: doc/BRIEF.md
# UART FIFO Interrupt Generator

This block produces the receive and transmit interrupt requests of a UART with receive and transmit FIFOs. It does not hold any data. It watches the fill level of each FIFO, the FIFO-enable setting and two programmable trigger levels. With the FIFOs off, it watches the single-character receive-present flag and the transmit-holding-empty flag instead. From these it keeps one raw status bit per direction. In every status and control vector, bit 0 is receive and bit 1 is transmit.

Each direction runs its own small state machine. The receive machine has three states: RX_QUIET (no request), RX_PENDING (request raised) and RX_SERVED (software cleared the request while the condition was still true). Its transitions are named *arm* (RX_QUIET to RX_PENDING when the condition holds), *drain* (RX_PENDING or RX_SERVED back to RX_QUIET when the condition goes false) and *ack* (RX_PENDING to RX_SERVED on a clear write, or on a data read when the FIFOs are off).

The transmit machine also has three states: TX_IDLE, TX_ARMED (data sits above the trigger) and TX_PENDING (request raised). Its transitions are named *load* (TX_IDLE or TX_PENDING to TX_ARMED when the fill goes above the trigger), *empty* (TX_ARMED to TX_PENDING when the fill falls to the trigger) and *ack* (TX_PENDING to TX_IDLE on a clear write). Because of this, the transmit request is caused by data draining. It is never raised just because the FIFO was already empty when the interrupt was enabled. A mask vector gates the raw bits into the masked status, and the masked bits are ORed into a single interrupt line.

Top module: `uart_irq_gen`

## Requirements
- R1: With fifo_en=1, raw_stat[0] becomes 1 one clock after rx_level is at or above the receive trigger.
- R2: With fifo_en=1, raw_stat[0] stays 1 until a clear write or until rx_level falls below the trigger. After a clear while rx_level is still at or above the trigger, it stays 0 until rx_level falls below the trigger and then reaches it again.
- R3: With fifo_en=0, raw_stat[0] becomes 1 one clock after rx_present is 1. It returns to 0 after a dr_read pulse or a clear write, and it does not set again until rx_present has gone to 0 and back to 1. It also returns to 0 when rx_present drops.
- R4: With fifo_en=1, raw_stat[1] becomes 1 only after tx_level has been above the transmit trigger and then falls to or below it. A FIFO that stays at or below the trigger from reset never raises it.
- R5: With fifo_en=1, raw_stat[1] stays 1 until a clear write or until tx_level goes above the trigger.
- R6: With fifo_en=0, raw_stat[1] becomes 1 one clock after tx_hold_empty goes from 0 to 1. It returns to 0 on a clear write or when tx_hold_empty goes to 0. An empty holding location from reset never raises it.
- R7: Trigger selection codes 0, 1, 2, 3 and 4 give thresholds of 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH (2, 4, 8, 12 and 14 for DEPTH=16). Codes 5 to 7 give 1/2.
- R8: mask_stat equals raw_stat AND irq_mask, bit by bit, and irq is the OR of mask_stat. Both are combinational.
- R9: A 1 in irq_clr clears the matching raw bit at the next clock. A 0 leaves that bit unchanged.
- R10: When a set condition and a clear write for the same bit occur in the same cycle, the bit becomes 1.
- R11: After reset, raw_stat, mask_stat and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-character mode |
| rx_level | input | LVL_W | Receive FIFO fill (0..DEPTH) |
| tx_level | input | LVL_W | Transmit FIFO fill (0..DEPTH) |
| rx_trig_sel | input | 3 | Receive trigger code (see R7) |
| tx_trig_sel | input | 3 | Transmit trigger code (see R7) |
| rx_present | input | 1 | A received character is held (FIFOs off) |
| tx_hold_empty | input | 1 | Transmit holding location is empty (FIFOs off) |
| dr_read | input | 1 | One-cycle strobe: the data register was read |
| irq_mask | input | 2 | Mask bits, bit 0 receive, bit 1 transmit |
| irq_clr | input | 2 | Write-one-to-clear pulse, bit 0 receive, bit 1 transmit |
| raw_stat | output | 2 | Raw interrupt status |
| mask_stat | output | 2 | Masked interrupt status |
| irq | output | 1 | Combined interrupt line |

## Verification
A receive machine stuck in RX_SERVED, or a transmit machine that skips TX_ARMED, shows up as a raw bit that differs from the level-derived expectation one clock after the level change that should have moved it. The level sweeps expose this on the very step where the fill crosses each of the eight trigger codes. An early or spurious transmit request appears as raw_stat[1] set during the upward sweep from an empty FIFO, where it must stay 0. A wrong clear or set-priority decision is visible on the single clock that follows the clear pulse.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        RX_QUIET   = 2'd0,
        RX_PENDING = 2'd1,
        RX_SERVED  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_ARMED   = 2'd1,
        TX_PENDING = 2'd2
    } tx_state_e;

    localparam int NUM_SRC   = 2;
    localparam int SRC_RX    = 0;
    localparam int SRC_TX    = 1;
    localparam int SEL_W     = 3;

    // Threshold in entries for a trigger code, used by the checker.
    function automatic int trig_entries(input logic [2:0] sel, input int depth);
        case (sel)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd3:    return (depth * 3) / 4;
            3'd4:    return (depth * 7) / 8;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [2:0]       sel,
    output logic [LVL_W-1:0] thresh
);
    localparam int EIGHTH = DEPTH / 8;

    always_comb begin
        unique case (sel)
            3'd0:    thresh = LVL_W'(EIGHTH);
            3'd1:    thresh = LVL_W'(EIGHTH * 2);
            3'd3:    thresh = LVL_W'(EIGHTH * 6);
            3'd4:    thresh = LVL_W'(EIGHTH * 7);
            default: thresh = LVL_W'(EIGHTH * 4);
        endcase
    end
endmodule

// File: rtl/uart_irq_rx.sv
module uart_irq_rx
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             present,
    input  logic             rd,
    input  logic             clr,
    output logic             raw
);
    rx_state_e state, state_nx;
    logic      cond;

    assign cond = fifo_en ? (level >= thresh) : present;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_QUIET:   if (cond) state_nx = RX_PENDING;
            RX_PENDING: begin
                if (!cond)                        state_nx = RX_QUIET;
                else if (clr || (!fifo_en && rd)) state_nx = RX_SERVED;
            end
            RX_SERVED:  if (!cond) state_nx = RX_QUIET;
            default:    state_nx = RX_QUIET;
        endcase
    end

    always_comb begin
        raw = (state == RX_PENDING);
    end
endmodule

// File: rtl/uart_irq_tx.sv
module uart_irq_tx
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             hold_empty,
    input  logic             clr,
    output logic             raw
);
    tx_state_e state, state_nx;
    logic      above;

    assign above = fifo_en ? (level > thresh) : !hold_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:    if (above) state_nx = TX_ARMED;
            TX_ARMED:   if (!above) state_nx = TX_PENDING;
            TX_PENDING: begin
                if (above)    state_nx = TX_ARMED;
                else if (clr) state_nx = TX_IDLE;
            end
            default:    state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        raw = (state == TX_PENDING);
    end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [2:0]       rx_trig_sel,
    input  logic [2:0]       tx_trig_sel,
    input  logic             rx_present,
    input  logic             tx_hold_empty,
    input  logic             dr_read,
    input  logic [1:0]       irq_mask,
    input  logic [1:0]       irq_clr,
    output logic [1:0]       raw_stat,
    output logic [1:0]       mask_stat,
    output logic             irq
);
    logic [SEL_W-1:0] sel_v [NUM_SRC];
    logic [LVL_W-1:0] thr_v [NUM_SRC];

    assign sel_v[SRC_RX] = rx_trig_sel;
    assign sel_v[SRC_TX] = tx_trig_sel;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_trig
        uart_irq_trig #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trig (
            .sel    (sel_v[g]),
            .thresh (thr_v[g])
        );
    end

    uart_irq_rx #(.LVL_W(LVL_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .level   (rx_level),
        .thresh  (thr_v[SRC_RX]),
        .present (rx_present),
        .rd      (dr_read),
        .clr     (irq_clr[SRC_RX]),
        .raw     (raw_stat[SRC_RX])
    );

    uart_irq_tx #(.LVL_W(LVL_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .level      (tx_level),
        .thresh     (thr_v[SRC_TX]),
        .hold_empty (tx_hold_empty),
        .clr        (irq_clr[SRC_TX]),
        .raw        (raw_stat[SRC_TX])
    );

    always_comb begin
        mask_stat = raw_stat & irq_mask;
        irq       = |mask_stat;
    end
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic [2:0]       rx_trig_sel,
    input logic [2:0]       tx_trig_sel,
    input logic [1:0]       irq_clr,
    input logic [1:0]       raw_stat,
    input logic             irq
);
    // R1: a receive request only rises after the fill met its threshold
    assert_rx_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(raw_stat[0]) && $past(fifo_en))
            |-> (int'($past(rx_level)) >= trig_entries($past(rx_trig_sel), DEPTH)));

    // R4: a transmit request only rises when the fill sat at or below its threshold
    assert_tx_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(raw_stat[1]) && $past(fifo_en))
            |-> (int'($past(tx_level)) <= trig_entries($past(tx_trig_sel), DEPTH)));

    // R9: a pending request is dropped by a clear write
    assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_stat[0]) && $past(irq_clr[0])) |-> !raw_stat[0]);

    assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_stat[1]) && $past(irq_clr[1])) |-> !raw_stat[1]);

    // R2: a pending receive request holds while the fill stays high and no clear arrives
    assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_stat[0]) && !$past(irq_clr[0]) && $past(fifo_en)
         && (int'($past(rx_level)) >= trig_entries($past(rx_trig_sel), DEPTH)))
            |-> raw_stat[0]);

    // R8: no raw request means no interrupt line
    assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat == 2'b00) |-> !irq);
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .rx_level    (rx_level),
    .tx_level    (tx_level),
    .rx_trig_sel (rx_trig_sel),
    .tx_trig_sel (tx_trig_sel),
    .irq_clr     (irq_clr),
    .raw_stat    (raw_stat),
    .irq         (irq)
);

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b1;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_level = '0;
    logic [2:0]       rx_trig_sel = '0;
    logic [2:0]       tx_trig_sel = '0;
    logic             rx_present = 1'b0;
    logic             tx_hold_empty = 1'b1;
    logic             dr_read = 1'b0;
    logic [1:0]       irq_mask = '0;
    logic [1:0]       irq_clr = '0;
    logic [1:0]       raw_stat;
    logic [1:0]       mask_stat;
    logic             irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_gen #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
        .rx_present(rx_present), .tx_hold_empty(tx_hold_empty),
        .dr_read(dr_read), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
    );

    function automatic int exp_trig(input int sel);
        int eighths;
        case (sel)
            0: eighths = 1;
            1: eighths = 2;
            3: eighths = 6;
            4: eighths = 7;
            default: eighths = 4;
        endcase
        return DEPTH * eighths / 8;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one clock; inputs are changed and outputs read 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
        irq_clr = '0;
        dr_read = 1'b0;
    endtask

    task automatic do_reset(input bit fen);
        rst_n = 1'b0;
        fifo_en = fen;
        rx_level = '0; tx_level = '0;
        rx_present = 1'b0; tx_hold_empty = 1'b1;
        irq_clr = '0; dr_read = 1'b0; irq_mask = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset(1'b1);
        irq_mask = 2'b11;
        #0;
        chk("R11 raw", int'(raw_stat), 0);
        chk("R11 irq", int'(irq), 0);

        // R1 R2 R7: receive fill sweep up then down per trigger code
        for (int s = 0; s < 8; s++) begin
            do_reset(1'b1);
            rx_trig_sel = 3'(s);
            for (int l = 0; l <= DEPTH; l++) begin
                rx_level = LVL_W'(l);
                step();
                chk($sformatf("R1/R7 rx up sel=%0d lvl=%0d", s, l),
                    int'(raw_stat[0]), (l >= exp_trig(s)) ? 1 : 0);
            end
            for (int l = DEPTH; l >= 0; l--) begin
                rx_level = LVL_W'(l);
                step();
                chk($sformatf("R2 rx down sel=%0d lvl=%0d", s, l),
                    int'(raw_stat[0]), (l >= exp_trig(s)) ? 1 : 0);
            end
        end

        // R4 R5 R7: transmit fill sweep up, down, up per trigger code
        for (int s = 0; s < 8; s++) begin
            do_reset(1'b1);
            tx_trig_sel = 3'(s);
            for (int l = 0; l <= DEPTH; l++) begin
                tx_level = LVL_W'(l);
                step();
                chk($sformatf("R4 tx fill sel=%0d lvl=%0d", s, l), int'(raw_stat[1]), 0);
            end
            for (int l = DEPTH; l >= 0; l--) begin
                tx_level = LVL_W'(l);
                step();
                chk($sformatf("R4/R7 tx drain sel=%0d lvl=%0d", s, l),
                    int'(raw_stat[1]), (l <= exp_trig(s)) ? 1 : 0);
            end
            for (int l = 0; l <= DEPTH; l++) begin
                tx_level = LVL_W'(l);
                step();
                chk($sformatf("R5 tx refill sel=%0d lvl=%0d", s, l),
                    int'(raw_stat[1]), (l <= exp_trig(s)) ? 1 : 0);
            end
        end

        // R9 R2: clear behaviour on receive, trigger 8
        do_reset(1'b1);
        rx_trig_sel = 3'd2;
        rx_level = LVL_W'(DEPTH);
        step();
        chk("R1 rx full", int'(raw_stat[0]), 1);
        irq_clr = 2'b10;
        step();
        chk("R9 zero clear keeps rx", int'(raw_stat[0]), 1);
        irq_clr = 2'b01;
        step();
        chk("R9 clear rx", int'(raw_stat[0]), 0);
        step(); step();
        chk("R2 rx stays served", int'(raw_stat[0]), 0);
        rx_level = '0;
        step();
        rx_level = LVL_W'(DEPTH);
        step();
        chk("R2 rx rearms", int'(raw_stat[0]), 1);

        // R10: set and clear same cycle, receive
        do_reset(1'b1);
        rx_trig_sel = 3'd0;
        rx_level = LVL_W'(DEPTH);
        irq_clr = 2'b01;
        step();
        chk("R10 rx set wins", int'(raw_stat[0]), 1);

        // R10 R9: transmit drain with clear in same cycle, then clear
        do_reset(1'b1);
        tx_trig_sel = 3'd0;
        tx_level = LVL_W'(DEPTH);
        step();
        tx_level = '0;
        irq_clr = 2'b10;
        step();
        chk("R10 tx set wins", int'(raw_stat[1]), 1);
        irq_clr = 2'b01;
        step();
        chk("R9 zero clear keeps tx", int'(raw_stat[1]), 1);
        irq_clr = 2'b10;
        step();
        chk("R9 clear tx", int'(raw_stat[1]), 0);
        step();
        chk("R5 tx stays idle after clear", int'(raw_stat[1]), 0);

        // R3: single-character receive
        do_reset(1'b0);
        rx_present = 1'b1;
        step();
        chk("R3 rx char", int'(raw_stat[0]), 1);
        dr_read = 1'b1;
        step();
        chk("R3 rx read", int'(raw_stat[0]), 0);
        step();
        chk("R3 rx no reassert", int'(raw_stat[0]), 0);
        rx_present = 1'b0;
        step();
        rx_present = 1'b1;
        step();
        chk("R3 rx next char", int'(raw_stat[0]), 1);
        rx_present = 1'b0;
        step();
        chk("R3 rx present drop", int'(raw_stat[0]), 0);
        rx_present = 1'b1;
        step();
        irq_clr = 2'b01;
        step();
        chk("R3 rx clear", int'(raw_stat[0]), 0);

        // R6: single-character transmit
        do_reset(1'b0);
        step(); step();
        chk("R6 tx empty from reset", int'(raw_stat[1]), 0);
        tx_hold_empty = 1'b0;
        step();
        chk("R6 tx loaded", int'(raw_stat[1]), 0);
        tx_hold_empty = 1'b1;
        step();
        chk("R6 tx emptied", int'(raw_stat[1]), 1);
        tx_hold_empty = 1'b0;
        step();
        chk("R6 tx refilled", int'(raw_stat[1]), 0);
        tx_hold_empty = 1'b1;
        step();
        irq_clr = 2'b10;
        step();
        chk("R6 tx clear", int'(raw_stat[1]), 0);

        // R8: mask combinations with both raw bits set
        do_reset(1'b1);
        rx_trig_sel = 3'd0; tx_trig_sel = 3'd0;
        rx_level = LVL_W'(DEPTH); tx_level = LVL_W'(DEPTH);
        step();
        tx_level = '0;
        step();
        chk("R8 both raw", int'(raw_stat), 3);
        for (int m = 0; m < 4; m++) begin
            irq_mask = 2'(m);
            #1;
            chk($sformatf("R8 mask_stat m=%0d", m), int'(mask_stat), m);
            chk($sformatf("R8 irq m=%0d", m), int'(irq), (m != 0) ? 1 : 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule